// File: doc/BRIEF.md
# GPIO Sticky Event Latch and Interrupt Router

This block watches a bank of general-purpose input pins and turns qualified activity on each pin into a sticky status bit. Pins are sampled only when the sample-enable strobe is high. A power controller drives that strobe at a fast rate while the system is running and at a slow real-time rate while it sleeps. So one design covers both a short pulse at fast sampling and a long one at slow sampling. A pin must be seen at its active level on two sample strobes in a row before its status bit sets. The active level is chosen per pin.

Each set status bit drives one of two interrupt outputs, a management interrupt or a configuration interrupt, through a per-pin two-bit routing field. It can also drive neither. Software reads the status through a small register port and clears it by writing ones. Status is level-retriggered: if the pin is still active when the bit is cleared, the next sample strobe sets it again without a new edge. Event capture for a pin stays off until software sets that pin's enable bit.

Top module: `gpio_event_router`

## Requirements
- R1: After reset every register reads zero, all status bits are clear and both interrupt outputs are low.
- R2: A pin whose enable bit (register address 0, bit i for pin i) is 0 never sets its status bit, whatever its level and the strobes.
- R3: A status bit sets only at a clock edge where sample_en_i is high and the pin has been active on that strobe and on the previous strobe. Pin levels between strobes are ignored, and a pin level must be held for 3 clocks before a strobe for it to be counted.
- R4: The polarity bit (address 1, bit i) selects the active level. 0 means active high and 1 means active low.
- R5: A set status bit stays set after its pin goes inactive until software clears it.
- R6: Writing 1 to bit i at address 3 clears status bit i on the next edge, and writing 0 leaves it unchanged. If pin i is still active, the next strobe sets the bit again.
- R7: When a clear write and a qualifying strobe for the same pin fall on the same clock edge, the status bit ends up set.
- R8: The routing field for pin i is bits [2i+1:2i] at address 2. 01 selects the management interrupt, 10 selects the configuration interrupt, and 00 or 11 selects neither. Each interrupt output is the OR of the status bits routed to it.
- R9: Addresses 0, 1 and 2 read back the last value written. Address 3 reads the status bits in [15:0], and all unused read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Sample strobe, fast when running, slow when asleep |
| pin_i | input | 16 | Asynchronous input pins |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| mgmt_irq_o | output | 1 | Management interrupt |
| cfg_irq_o | output | 1 | Configuration interrupt |

## Verification
The hardest case to reach from the ports is a clear write that lands on the same edge as the strobe that qualifies a still-active pin. Here set must win over clear. A second hard case is a clear that lands between strobes, so the bit must read zero briefly and then set again. The bench reaches the first case with a task that raises the strobe and the clear write in one cycle. It reaches the second by clearing while pins are held active. Random rounds mix these operations with polarity, routing and enable changes, and each step is compared against a per-pin model of strobe counts.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_MGMT = 2'b01,
    ROUTE_CFG  = 2'b10,
    ROUTE_RSVD = 2'b11
  } route_e;

  localparam logic [1:0] ADDR_EN    = 2'd0;
  localparam logic [1:0] ADDR_POL   = 2'd1;
  localparam logic [1:0] ADDR_ROUTE = 2'd2;
  localparam logic [1:0] ADDR_STAT  = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_qual.sv
module gpio_qual #(
  parameter int unsigned QUAL = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic en_i,
  input  logic active_i,
  input  logic clr_i,
  output logic status_o
);
  localparam int unsigned CW = (QUAL < 2) ? 1 : $clog2(QUAL);
  localparam logic [CW-1:0] CMAX = CW'(QUAL - 1);

  logic [CW-1:0] cnt_q;
  logic          status_q;
  logic          hit;

  // qualifying strobe: active now and on the previous QUAL-1 strobes
  assign hit = strobe_i & en_i & active_i & (cnt_q == CMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (!en_i)               cnt_q <= '0;
      else if (strobe_i) begin
        if (!active_i)         cnt_q <= '0;
        else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      end
      status_q <= (status_q & ~clr_i) | hit;  // set wins
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_route.sv
module gpio_route
  import gpio_evt_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]   status_i,
  input  logic [2*N-1:0] route_i,
  output logic           mgmt_o,
  output logic           cfg_o
);
  logic [N-1:0] to_mgmt, to_cfg;

  for (genvar i = 0; i < N; i++) begin : g_dec
    route_e sel;
    assign sel = route_e'(route_i[2*i +: 2]);
    always_comb begin
      to_mgmt[i] = 1'b0;
      to_cfg[i]  = 1'b0;
      case (sel)
        ROUTE_MGMT: to_mgmt[i] = status_i[i];
        ROUTE_CFG:  to_cfg[i]  = status_i[i];
        default: ;
      endcase
    end
  end

  assign mgmt_o = |to_mgmt;
  assign cfg_o  = |to_cfg;
endmodule

// File: rtl/gpio_event_router.sv
module gpio_event_router
  import gpio_evt_pkg::*;
#(
  parameter int unsigned N    = 16,
  parameter int unsigned QUAL = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sample_en_i,
  input  logic [N-1:0]   pin_i,
  input  logic           reg_we_i,
  input  logic [1:0]     reg_addr_i,
  input  logic [2*N-1:0] reg_wdata_i,
  output logic [2*N-1:0] reg_rdata_o,
  output logic           mgmt_irq_o,
  output logic           cfg_irq_o
);
  localparam int unsigned DW = 2 * N;

  logic [N-1:0]  en_q, pol_q;
  logic [DW-1:0] route_q;
  logic [N-1:0]  pin_s, active, clr_mask, status_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      pol_q   <= '0;
      route_q <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        ADDR_EN:    en_q    <= reg_wdata_i[N-1:0];
        ADDR_POL:   pol_q   <= reg_wdata_i[N-1:0];
        ADDR_ROUTE: route_q <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_mask = (reg_we_i && reg_addr_i == ADDR_STAT) ? reg_wdata_i[N-1:0] : '0;

  gpio_sync #(.N(N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  assign active = pin_s ^ pol_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    gpio_qual #(.QUAL(QUAL)) u_qual (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .strobe_i(sample_en_i),
      .en_i    (en_q[i]),
      .active_i(active[i]),
      .clr_i   (clr_mask[i]),
      .status_o(status_w[i])
    );
  end

  gpio_route #(.N(N)) u_route (
    .status_i(status_w),
    .route_i (route_q),
    .mgmt_o  (mgmt_irq_o),
    .cfg_o   (cfg_irq_o)
  );

  always_comb begin
    case (reg_addr_i)
      ADDR_EN:    reg_rdata_o = {{N{1'b0}}, en_q};
      ADDR_POL:   reg_rdata_o = {{N{1'b0}}, pol_q};
      ADDR_ROUTE: reg_rdata_o = route_q;
      default:    reg_rdata_o = {{N{1'b0}}, status_w};
    endcase
  end
endmodule

// File: rtl/gpio_event_router_chk.sv
module gpio_event_router_chk #(
  parameter int unsigned N = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sample_en_i,
  input logic           reg_we_i,
  input logic [1:0]     reg_addr_i,
  input logic [2*N-1:0] reg_wdata_i,
  input logic [N-1:0]   status_i,
  input logic [N-1:0]   en_i,
  input logic           mgmt_irq_o,
  input logic           cfg_irq_o
);
  logic [N-1:0] clr_m;
  assign clr_m = (reg_we_i && reg_addr_i == 2'd3) ? reg_wdata_i[N-1:0] : '0;

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & $past(status_i & ~clr_m)) == $past(status_i & ~clr_m)));

  a_r6_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> ((status_i & $past(clr_m)) == '0));

  a_r3_set_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> ((status_i & ~$past(status_i)) == '0));

  a_r2_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & ~$past(status_i) & ~$past(en_i)) == '0));

  a_r8_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_irq_o || cfg_irq_o) |-> (status_i != '0));
endmodule

bind gpio_event_router gpio_event_router_chk #(.N(N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sample_en_i(sample_en_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .status_i   (status_w),
  .en_i       (en_q),
  .mgmt_irq_o (mgmt_irq_o),
  .cfg_irq_o  (cfg_irq_o)
);

// File: tb/gpio_event_router_test.sv
module gpio_event_router_test;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          se = 1'b0;
  logic [N-1:0]  pins = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          mgmt, cfg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0] m_en = '0, m_pol = '0, m_stat = '0;
  logic [31:0]  m_route = '0;
  int           m_cnt [N];

  always #2 clk = ~clk;

  gpio_event_router uut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_en_i(se), .pin_i(pins),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .mgmt_irq_o(mgmt), .cfg_irq_o(cfg)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq(logic [1:0] code);
    logic r = 1'b0;
    for (int i = 0; i < N; i++)
      if (m_stat[i] && m_route[2*i +: 2] == code) r = 1'b1;
    return r;
  endfunction

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1 v = rdata;
  endtask

  task automatic compare(string req);
    logic [31:0] v;
    rd(2'd3, v);
    check({req, " status"}, v, {16'h0, m_stat});
    check({req, " mgmt"}, {31'h0, mgmt}, {31'h0, exp_irq(2'b01)});
    check({req, " cfg"}, {31'h0, cfg}, {31'h0, exp_irq(2'b10)});
  endtask

  function automatic void model_strobe();
    for (int i = 0; i < N; i++) begin
      if (m_en[i] && (pins[i] ^ m_pol[i])) begin
        if (m_cnt[i] < 2) m_cnt[i]++;
        if (m_cnt[i] >= 2) m_stat[i] = 1'b1;
      end else m_cnt[i] = 0;
    end
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    case (a)
      2'd0: begin
        for (int i = 0; i < N; i++) if (!d[i]) m_cnt[i] = 0;
        m_en = d[N-1:0];
      end
      2'd1: m_pol = d[N-1:0];
      2'd2: m_route = d;
      default: m_stat = m_stat & ~d[N-1:0];
    endcase
  endtask

  task automatic set_pins(logic [N-1:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk);
    se = 1'b1;
    @(negedge clk);
    se = 1'b0;
    model_strobe();
  endtask

  task automatic clear_with_strobe(logic [N-1:0] c);
    @(negedge clk);
    we = 1'b1; addr = 2'd3; wdata = {16'h0, c}; se = 1'b1;
    @(negedge clk);
    we = 1'b0; se = 1'b0;
    m_stat = m_stat & ~c;
    model_strobe();
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = 32'd20240611;
    v = $urandom(seed);
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reg reset", v, 32'h0);
    end
    check("R1 irq reset", {30'h0, mgmt, cfg}, 32'h0);

    // R2 capture off before enable
    set_pins(16'hFFFF);
    strobe(); strobe(); strobe();
    compare("R2 not enabled");

    // R9 readback
    wr(2'd0, 32'h0000FFFF);
    wr(2'd1, 32'h0000A5C3);
    wr(2'd2, 32'h1234ABCD);
    rd(2'd0, v); check("R9 enable readback", v, 32'h0000FFFF);
    rd(2'd1, v); check("R9 polarity readback", v, 32'h0000A5C3);
    rd(2'd2, v); check("R9 route readback", v, 32'h1234ABCD);
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h000000E4);  // pin0=00 pin1=01 pin2=10 pin3=11
    set_pins(16'h0000);
    strobe(); strobe();
    compare("R9 idle");

    // R3 two strobes needed
    set_pins(16'h000F);
    strobe();
    compare("R3 one strobe");
    strobe();
    compare("R3 two strobes");
    check("R8 mgmt routed", {31'h0, mgmt}, 32'h1);
    check("R8 cfg routed", {31'h0, cfg}, 32'h1);

    // R6 clear while active, then retrigger
    wr(2'd3, 32'h00000007);
    compare("R6 clear");
    check("R8 code 11 none", {30'h0, mgmt, cfg}, 32'h0);
    strobe();
    compare("R6 retrigger");

    // R5 sticky after release
    set_pins(16'h0000);
    strobe(); strobe();
    compare("R5 sticky");
    wr(2'd3, 32'h0000FFFF);
    compare("R6 clear all");

    // R3 single strobe pulse and between-strobe pulse ignored
    set_pins(16'h0020);
    strobe();
    set_pins(16'h0000);
    strobe();
    compare("R3 single pulse");
    set_pins(16'h0040);
    set_pins(16'h0000);
    strobe(); strobe();
    compare("R3 between strobes");

    // R4 active low
    wr(2'd1, 32'h00000040);
    strobe(); strobe();
    compare("R4 active low");
    wr(2'd1, 32'h0);
    wr(2'd3, 32'h0000FFFF);

    // R2 per-pin disable
    wr(2'd0, 32'h0000FF7F);
    set_pins(16'h0080);
    strobe(); strobe(); strobe();
    compare("R2 disabled pin");

    // R7 set wins over clear
    wr(2'd0, 32'h0000FFFF);
    set_pins(16'h0100);
    strobe(); strobe();
    clear_with_strobe(16'h0100);
    compare("R7 set wins");
    set_pins(16'h0000);
    clear_with_strobe(16'h0100);
    compare("R7 clear inactive");

    // random mix
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 8)
        0: set_pins(16'($urandom));
        1: wr(2'd1, $urandom & 32'h0000FFFF);
        2: wr(2'd2, $urandom);
        3: wr(2'd0, ($urandom % 4 == 0) ? ($urandom & 32'h0000FFFF) : 32'h0000FFFF);
        4: wr(2'd3, $urandom & 32'h0000FFFF);
        5: clear_with_strobe(16'($urandom));
        default: strobe();
      endcase
      compare("R8 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule